// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block is a synchronous bank of eight ownership flags shared by two independent ports, called left and right. Software on either side claims a shared resource by writing 0 to a flag and then reading that flag back. A read of 0 means the claim succeeded. A read of 1 means the other side holds the flag. Writing 1 gives the flag up, or withdraws a claim that is still waiting. A claim that was refused is not lost. It stays recorded in the flag, and the flag passes to the waiting side in the same clock edge on which the holder releases it.

Each port has a semaphore select, a write strobe, a read strobe, an address, a single write bit and a registered read bus. Only the low three address bits pick a flag. A port that raises its memory enable together with its semaphore select makes an illegal access, and the block discards it. When both ports claim the same free flag in the same cycle, a priority bit picks one winner and records the loser as waiting. The priority bit flips after every such tie.

Every flag is a small state machine with five states. `SEM_FREE` means no side holds the flag. `SEM_HELD_L` and `SEM_HELD_R` mean one side holds it and nothing is waiting. `SEM_HELD_L_WAIT_R` and `SEM_HELD_R_WAIT_L` mean one side holds it and the other side's claim is waiting. The transitions are:
- grant: `SEM_FREE` to `SEM_HELD_x`.
- tie split: `SEM_FREE` to `SEM_HELD_x_WAIT_y`, with the winner chosen by priority.
- deny and record: `SEM_HELD_x` to `SEM_HELD_x_WAIT_y`.
- release to free: `SEM_HELD_x` to `SEM_FREE`.
- handover: `SEM_HELD_x_WAIT_y` to `SEM_HELD_y`, and also `SEM_HELD_x` to `SEM_HELD_y` when the release and the other side's claim fall in the same cycle.
- cancel: `SEM_HELD_x_WAIT_y` to `SEM_HELD_x`.
- double drop: `SEM_HELD_x_WAIT_y` to `SEM_FREE`, when the holder releases and the waiter cancels in the same cycle.

Top module: `sem_pair_unit`

## Requirements
- R1: A synchronous reset (`rst` high) puts all eight flags in `SEM_FREE` with nothing waiting, resets the priority to favour left, and sets both read buses to 8'hFF.
- R2: A read captures the addressed flag on the next clock edge. The result is 8'h00 if the reading port holds the flag and 8'hFF otherwise. A free flag reads 8'hFF on both ports. A claim (write with `wbit`=0) on a free flag grants it at once to the claiming port.
- R3: While a flag is held, a claim from the other port is refused. A repeated claim by the holder changes nothing. The holder keeps reading 8'h00 and the other port reads 8'hFF.
- R4: A refused claim is recorded. When the holder then writes `wbit`=1, the waiting port holds the flag from that clock edge on.
- R5: When nothing is waiting, a release by the holder frees the flag. A waiting port that writes `wbit`=1 withdraws its claim. A later release by the holder then leaves the flag free.
- R6: Claims by both ports on the same free flag in one cycle give exactly one holder. Left wins the first tie after reset, and the winner alternates on each later tie. The loser is recorded as waiting.
- R7: Only address bits [2:0] select the flag. All higher address bits have no effect on reads or writes.
- R8: The read bus of a port changes only on a read by that port. Writes from either port leave it unchanged until that port's next read. A read in the same cycle as a write captures the state from before the write.
- R9: An access with both `mem_en` and `sel` high on a port is ignored completely. Its write changes no flag and its read leaves the read bus unchanged.
- R10: A read issued in the cycle right after a write to the same flag returns the updated state.
- R11: An operation on one flag leaves the state of every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_mem_en | input | 1 | Left memory enable; with l_sel high the access is illegal |
| l_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | 12 | Left address; bits [2:0] pick the flag |
| l_wbit | input | 1 | Left write bit: 0 claims, 1 releases or withdraws |
| l_rdata | output | 8 | Left registered read data |
| r_mem_en | input | 1 | Right memory enable; with r_sel high the access is illegal |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | 12 | Right address; bits [2:0] pick the flag |
| r_wbit | input | 1 | Right write bit: 0 claims, 1 releases or withdraws |
| r_rdata | output | 8 | Right registered read data |

## Verification
Two pairs of functions can land in the same cycle. The first pair is claims from both ports on one free flag, which exercises the tie split. The second pair is one port's read and the other port's write, or its own write, to the same flag. The bench provokes the tie three times in a row and checks that the winner goes left, then right, then left. It also checks that each loser becomes holder on the winner's release. For the read-write overlap, the bench issues the read and the write in the same cycle and expects the read bus to show the state from before the write. It then expects the bus to stay frozen through later writes until that port reads again.

// File: rtl/sem_pair_pkg.sv
package sem_pair_pkg;

    // Per-flag ownership state; *_WAIT_* states carry a recorded refused claim.
    typedef enum logic [2:0] {
        SEM_FREE          = 3'd0,
        SEM_HELD_L        = 3'd1,
        SEM_HELD_R        = 3'd2,
        SEM_HELD_L_WAIT_R = 3'd3,
        SEM_HELD_R_WAIT_L = 3'd4
    } sem_state_e;

endpackage

// File: rtl/sem_port_decode.sv
// Qualifies one port's strobes and decodes the flag index into one-hot
// claim / release vectors (R7, R9).
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               mem_en,
    input  logic               sel,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wbit,
    output logic [NUM_SEM-1:0] claim_vec,
    output logic [NUM_SEM-1:0] drop_vec,
    output logic               rd_go,
    output logic [IDX_W-1:0]   rd_idx
);

    logic             legal;
    logic             wr_go;
    logic [IDX_W-1:0] idx;
    logic             unused_hi;

    // R9: memory enable together with select voids the whole access
    assign legal  = sel && !mem_en;
    assign wr_go  = legal && wr;
    assign rd_go  = legal && rd;
    // R7: only the low index bits take part
    assign idx    = addr[IDX_W-1:0];
    assign rd_idx = idx;
    assign unused_hi = ^addr[ADDR_W-1:IDX_W];

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
        assign claim_vec[i] = wr_go && (idx == IDX_W'(i)) && !wbit;
        assign drop_vec[i]  = wr_go && (idx == IDX_W'(i)) &&  wbit;
    end

endmodule

// File: rtl/sem_flag_fsm.sv
// One ownership flag: grant, refusal with recording, handover, cancel, tie split.
module sem_flag_fsm
    import sem_pair_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic prio_left,
    input  logic claim_l,
    input  logic drop_l,
    input  logic claim_r,
    input  logic drop_r,
    output logic own_l,
    output logic own_r,
    output logic tie
);

    sem_state_e state_q;
    sem_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEM_FREE;     // R1
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (claim_l && claim_r)   // R6 tie split
                    state_d = prio_left ? SEM_HELD_L_WAIT_R : SEM_HELD_R_WAIT_L;
                else if (claim_l)         // R2 grant
                    state_d = SEM_HELD_L;
                else if (claim_r)
                    state_d = SEM_HELD_R;
            end
            SEM_HELD_L: begin
                if (drop_l)               // R5 release / R4 same-cycle handover
                    state_d = claim_r ? SEM_HELD_R : SEM_FREE;
                else if (claim_r)         // R3 deny and record
                    state_d = SEM_HELD_L_WAIT_R;
            end
            SEM_HELD_R: begin
                if (drop_r)
                    state_d = claim_l ? SEM_HELD_L : SEM_FREE;
                else if (claim_l)
                    state_d = SEM_HELD_R_WAIT_L;
            end
            SEM_HELD_L_WAIT_R: begin
                if (drop_l && drop_r)     // double drop
                    state_d = SEM_FREE;
                else if (drop_l)          // R4 handover
                    state_d = SEM_HELD_R;
                else if (drop_r)          // R5 cancel
                    state_d = SEM_HELD_L;
            end
            SEM_HELD_R_WAIT_L: begin
                if (drop_l && drop_r)
                    state_d = SEM_FREE;
                else if (drop_r)
                    state_d = SEM_HELD_L;
                else if (drop_l)
                    state_d = SEM_HELD_R;
            end
            default: state_d = SEM_FREE;
        endcase
    end

    // outputs
    always_comb begin
        own_l = 1'b0;
        own_r = 1'b0;
        tie   = 1'b0;
        unique case (state_q)
            SEM_FREE:          tie   = claim_l && claim_r;
            SEM_HELD_L:        own_l = 1'b1;
            SEM_HELD_L_WAIT_R: own_l = 1'b1;
            SEM_HELD_R:        own_r = 1'b1;
            SEM_HELD_R_WAIT_L: own_r = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sem_tie_prio.sv
// Alternating tie-break priority shared by all flags (R6).
module sem_tie_prio #(
    parameter int NUM_SEM = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SEM-1:0] tie_vec,
    output logic               prio_left
);

    always_ff @(posedge clk) begin
        if (rst)           prio_left <= 1'b1;
        else if (|tie_vec) prio_left <= !prio_left;
    end

endmodule

// File: rtl/sem_read_reg.sv
// Per-port read capture register: holds its value between reads (R8).
module sem_read_reg #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_go,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [NUM_SEM-1:0] own_vec,
    output logic [DATA_W-1:0]  rdata
);

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '1;                          // R1
        else if (rd_go) rdata <= {DATA_W{!own_vec[rd_idx]}};  // R2
    end

endmodule

// File: rtl/sem_pair_unit.sv
module sem_pair_unit #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_mem_en,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wbit,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_mem_en,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wbit,
    output logic [DATA_W-1:0] r_rdata
);

    logic [NUM_SEM-1:0] claim_l, drop_l, claim_r, drop_r;
    logic [NUM_SEM-1:0] own_l, own_r, tie_vec;
    logic               rd_go_l, rd_go_r;
    logic [IDX_W-1:0]   rd_idx_l, rd_idx_r;
    logic               prio_left;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_l (
        .mem_en(l_mem_en), .sel(l_sel), .wr(l_wr), .rd(l_rd),
        .addr(l_addr), .wbit(l_wbit),
        .claim_vec(claim_l), .drop_vec(drop_l),
        .rd_go(rd_go_l), .rd_idx(rd_idx_l)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_r (
        .mem_en(r_mem_en), .sel(r_sel), .wr(r_wr), .rd(r_rd),
        .addr(r_addr), .wbit(r_wbit),
        .claim_vec(claim_r), .drop_vec(drop_r),
        .rd_go(rd_go_r), .rd_idx(rd_idx_r)
    );

    sem_tie_prio #(.NUM_SEM(NUM_SEM)) u_prio (
        .clk(clk), .rst(rst), .tie_vec(tie_vec), .prio_left(prio_left)
    );

    // R11: one independent state machine per flag
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_flag
        sem_flag_fsm u_flag (
            .clk(clk), .rst(rst), .prio_left(prio_left),
            .claim_l(claim_l[i]), .drop_l(drop_l[i]),
            .claim_r(claim_r[i]), .drop_r(drop_r[i]),
            .own_l(own_l[i]), .own_r(own_r[i]), .tie(tie_vec[i])
        );
    end

    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst(rst), .rd_go(rd_go_l), .rd_idx(rd_idx_l),
        .own_vec(own_l), .rdata(l_rdata)
    );

    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst(rst), .rd_go(rd_go_r), .rd_idx(rd_idx_r),
        .own_vec(own_r), .rdata(r_rdata)
    );

endmodule

// File: rtl/sem_pair_checker.sv
module sem_pair_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              l_mem_en,
    input logic              l_sel,
    input logic              l_rd,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              r_mem_en,
    input logic              r_sel,
    input logic              r_rd,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata
);

    logic rd_l_ok, rd_r_ok;
    assign rd_l_ok = l_sel && l_rd && !l_mem_en;
    assign rd_r_ok = r_sel && r_rd && !r_mem_en;

    assert_reset_view_R1: assert property (@(posedge clk)
        rst |=> (l_rdata == '1 && r_rdata == '1));

    assert_rdata_uniform_R2: assert property (@(posedge clk) disable iff (rst)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    assert_single_holder_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_l_ok && rd_r_ok && l_addr[IDX_W-1:0] == r_addr[IDX_W-1:0])
        |=> !(l_rdata == '0 && r_rdata == '0));

    assert_left_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_l_ok |=> $stable(l_rdata));

    assert_right_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_r_ok |=> $stable(r_rdata));

    assert_illegal_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (l_sel && l_mem_en) |=> $stable(l_rdata));

endmodule

bind sem_pair_unit sem_pair_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst),
    .l_mem_en(l_mem_en), .l_sel(l_sel), .l_rd(l_rd), .l_addr(l_addr), .l_rdata(l_rdata),
    .r_mem_en(r_mem_en), .r_sel(r_sel), .r_rd(r_rd), .r_addr(r_addr), .r_rdata(r_rdata)
);

// File: tb/sim_sem_pair_unit.sv
`timescale 1ns/1ps
module sim_sem_pair_unit;

    localparam logic [7:0] FREE_V = 8'hFF;
    localparam logic [7:0] MINE_V = 8'h00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        l_mem_en, l_sel, l_wr, l_rd, l_wbit;
    logic        r_mem_en, r_sel, r_wr, r_rd, r_wbit;
    logic [11:0] l_addr, r_addr;
    logic [7:0]  l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;

    // scoreboard: {port, expected}, with tag
    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic       stg_v[2];
    logic [7:0] stg_e[2];
    string      stg_t[2];

    always #2.5 clk = !clk;

    sem_pair_unit u0 (
        .clk(clk), .rst(rst),
        .l_mem_en(l_mem_en), .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd),
        .l_addr(l_addr), .l_wbit(l_wbit), .l_rdata(l_rdata),
        .r_mem_en(r_mem_en), .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd),
        .r_addr(r_addr), .r_wbit(r_wbit), .r_rdata(r_rdata)
    );

    task automatic compare(input bit port, input logic [7:0] exp, input string tag);
        logic [7:0] act;
        act = port ? r_rdata : l_rdata;
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port=%s actual=%h expected=%h", tag, port ? "R" : "L", act, exp);
        end
    endtask

    // monitor: pops due items away from the capturing edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                logic [8:0] it;
                string      tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                compare(it[8], it[7:0], tg);
            end
        end
    end

    task automatic clear_in();
        l_mem_en = 0; l_sel = 0; l_wr = 0; l_rd = 0; l_addr = '0; l_wbit = 0;
        r_mem_en = 0; r_sel = 0; r_wr = 0; r_rd = 0; r_addr = '0; r_wbit = 0;
    endtask

    task automatic wr_op(input bit port, input logic [11:0] a, input bit b, input bit men = 0);
        if (!port) begin l_sel = 1; l_wr = 1; l_addr = a; l_wbit = b; l_mem_en = men; end
        else       begin r_sel = 1; r_wr = 1; r_addr = a; r_wbit = b; r_mem_en = men; end
    endtask

    task automatic rd_op(input bit port, input logic [11:0] a, input logic [7:0] exp,
                         input string tag);
        if (!port) begin l_sel = 1; l_rd = 1; l_addr = a; end
        else       begin r_sel = 1; r_rd = 1; r_addr = a; end
        stg_v[port] = 1'b1; stg_e[port] = exp; stg_t[port] = tag;
    endtask

    // one clock: apply inputs, queue expectations after the capturing edge
    task automatic fire();
        @(posedge clk);
        #1;
        for (int p = 0; p < 2; p++) begin
            if (stg_v[p]) begin
                exp_q.push_back({p[0], stg_e[p]});
                tag_q.push_back(stg_t[p]);
                stg_v[p] = 1'b0;
            end
        end
        @(negedge clk);
        clear_in();
    endtask

    task automatic rd_both(input logic [11:0] a, input logic [7:0] el, input logic [7:0] er,
                           input string tag);
        rd_op(0, a, el, tag);
        rd_op(1, a, er, tag);
        fire();
    endtask

    // watchdog
    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        stg_v[0] = 0; stg_v[1] = 0;
        clear_in();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset view on both ports, every flag free
        compare(0, FREE_V, "R1");
        compare(1, FREE_V, "R1");
        for (int i = 0; i < 8; i++) rd_both(12'(i), FREE_V, FREE_V, "R1");

        // R2: grant on free flag; R10: read right after write
        wr_op(0, 12'd2, 0); fire();
        rd_both(12'd2, MINE_V, FREE_V, "R2");
        // R3: other side refused, holder repeat claim no effect
        wr_op(1, 12'd2, 0); fire();
        rd_both(12'd2, MINE_V, FREE_V, "R3");
        wr_op(0, 12'd2, 0); fire();
        rd_both(12'd2, MINE_V, FREE_V, "R3");
        // R4: handover on release
        wr_op(0, 12'd2, 1); fire();
        rd_both(12'd2, FREE_V, MINE_V, "R4");
        // R5: release with nothing waiting frees it
        wr_op(1, 12'd2, 1); fire();
        rd_both(12'd2, FREE_V, FREE_V, "R5");

        // R5: waiting claim withdrawn
        wr_op(0, 12'd5, 0); fire();
        wr_op(1, 12'd5, 0); fire();
        wr_op(1, 12'd5, 1); fire();
        rd_both(12'd5, MINE_V, FREE_V, "R5");
        wr_op(0, 12'd5, 1); fire();
        rd_both(12'd5, FREE_V, FREE_V, "R5");

        // R6: ties alternate L, R, L; loser waits
        wr_op(0, 12'd3, 0); wr_op(1, 12'd3, 0); fire();
        rd_both(12'd3, MINE_V, FREE_V, "R6");
        wr_op(0, 12'd3, 1); fire();
        rd_both(12'd3, FREE_V, MINE_V, "R6");
        wr_op(1, 12'd3, 1); fire();
        wr_op(0, 12'd3, 0); wr_op(1, 12'd3, 0); fire();
        rd_both(12'd3, FREE_V, MINE_V, "R6");
        wr_op(1, 12'd3, 1); fire();
        rd_both(12'd3, MINE_V, FREE_V, "R6");
        wr_op(0, 12'd3, 1); fire();
        wr_op(0, 12'd1, 0); wr_op(1, 12'd1, 0); fire();
        rd_both(12'd1, MINE_V, FREE_V, "R6");
        // double drop: holder release + waiter cancel together
        wr_op(0, 12'd1, 1); wr_op(1, 12'd1, 1); fire();
        rd_both(12'd1, FREE_V, FREE_V, "R6");

        // R7: upper address bits ignored
        wr_op(0, 12'hA04, 0); fire();
        rd_op(0, 12'h004, MINE_V, "R7"); rd_op(1, 12'h5C4, FREE_V, "R7"); fire();
        wr_op(0, 12'hFFC, 1); fire();
        rd_both(12'd4, FREE_V, FREE_V, "R7");

        // R8: read register holds through other writes
        wr_op(0, 12'd6, 0); fire();
        rd_op(0, 12'd6, MINE_V, "R8"); fire();
        wr_op(1, 12'd6, 0); fire();
        wr_op(0, 12'd6, 1); fire();
        compare(0, MINE_V, "R8");
        // R8: read in the same cycle as a write sees pre-write state
        rd_op(1, 12'd6, MINE_V, "R8"); wr_op(0, 12'd6, 0); fire();
        wr_op(1, 12'd6, 1); fire();
        compare(1, MINE_V, "R8");
        rd_both(12'd6, MINE_V, FREE_V, "R8");
        wr_op(0, 12'd6, 1); fire();

        // R9: illegal accesses ignored
        wr_op(0, 12'd7, 0, 1); fire();
        rd_both(12'd7, FREE_V, FREE_V, "R9");
        wr_op(0, 12'd7, 0); fire();
        rd_op(0, 12'd7, MINE_V, "R9"); fire();
        l_sel = 1; l_rd = 1; l_mem_en = 1; l_addr = 12'd0; fire();
        compare(0, MINE_V, "R9");
        wr_op(0, 12'd7, 1, 1); fire();
        rd_op(0, 12'd7, MINE_V, "R9"); fire();

        // R11: other flags untouched while 7 is held
        for (int i = 0; i < 7; i++) rd_both(12'(i), FREE_V, FREE_V, "R11");
        // R10: read the cycle after release
        wr_op(0, 12'd7, 1); fire();
        rd_both(12'd7, FREE_V, FREE_V, "R10");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule